// File: doc/BRIEF.md
# MDIO Station-Management Master

This block lets a host read and write 16-bit PHY management registers over the two-wire MDC/MDIO serial bus. The host sees two registers. One is a packed control word holding the PHY address, the register number, a write-select bit, a clock-range code and a busy bit. The other is a 16-bit data register. The host loads the data register first if it wants a write. It then writes the control word with the busy bit set, which starts a transaction. It polls busy until it drops and, for a read, picks the result up from the data register.

The MDC clock is derived from the system clock by one of five divide ratios: 16, 26, 42, 62 or 102. The ratio is chosen so that MDC stays under the bus limit for the system clock in use:

| System clock | Ratio |
|---|---|
| 20 to 35 MHz | /16 |
| 35 to 60 MHz | /26 |
| 60 to 100 MHz | /42 |
| 100 to 150 MHz | /62 |
| above 150 MHz | /102 |

Each transaction is one complete 64-bit frame. The block drives the MDIO output enable itself and releases the line while the PHY answers a read.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy reads 0 and MDC is low. The MDIO output enable is low, and the clock-range code reads 2, which selects /16.
- R2: Control word layout: bit 0 is busy/launch, bit 1 is write-select (1 means write), bits 4:2 are the clock-range code, bits 10:6 are the register number, bits 15:11 are the PHY address, and bit 5 reads 0. A control write with bit 0 clear updates the fields and starts nothing.
- R3: Clock-range codes map to divide ratios as 0→42, 1→62, 2→16, 3→26, and 4 to 7→102. MDC is high for ratio/2 system cycles and low for ratio/2. Busy stays high for exactly 64×ratio cycles after the launching edge.
- R4: A write frame carries, MSB first, 32 ones, then 01, 01, the PHY address, the register number, 10, and the 16-bit data register. The output enable is high for all 64 bits.
- R5: A read frame carries 32 ones, then 01, 10, the PHY address and the register number, with the output enable high. The output enable is low for the last 18 bits (turnaround and data).
- R6: In a read, the block samples MDIO on the MDC rising edge of each of the last 16 bits, MSB first. When busy clears, the result appears in the data register.
- R7: MDIO and its output enable change only when MDC falls. They stay stable while MDC is high.
- R8: A control write while busy is high is ignored. The fields read back unchanged, and the frame in flight is unaffected.
- R9: All control fields, including the clock-range code, keep their values after a transaction completes.
- R10: While busy is low, MDC is low and the MDIO output enable is low.
- R11: A data-register write while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Write strobe for the control word |
| data_we_i | input | 1 | Write strobe for the data register |
| wdata_i | input | 16 | Host write data for either register |
| ctrl_rdata_o | output | 16 | Control word readback, including busy |
| data_rdata_o | output | 16 | Data register readback |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value to the pad |
| mdio_oe_o | output | 1 | MDIO output enable, high means driven |

## Verification
The assertions assume that the host raises the two write strobes only as single-cycle pulses. They also assume that nobody touches the clock-range code except through the control word, so the code cannot change in the middle of a frame. The bench keeps within this: each strobe is held for exactly one clock, and it never writes the data register on the same edge that launches a frame. When the bench sends control and data writes while busy is high, it does so deliberately, to show they are ignored, and it checks afterwards that the frame on the wire is still the one originally launched. The PHY model changes MDIO only after an MDC fall, so the value the block samples on the rising edge is always settled.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PREAMBLE_LEN = 32;
  localparam int DATA_W       = 16;
  localparam int ADDR_W       = 5;
  localparam int CODE_W       = 3;
  localparam int CTRL_W       = 16;
  localparam int HALF_W       = 6;
  localparam int FRAME_LEN    = PREAMBLE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W        = $clog2(FRAME_LEN);
  localparam int TA_POS       = FRAME_LEN - DATA_W - 2;

  // control word bit positions are software-visible
  localparam int BUSY_BIT = 0;
  localparam int WR_BIT   = 1;
  localparam int CODE_LSB = 2;
  localparam int REG_LSB  = 6;
  localparam int PHY_LSB  = 11;

  localparam logic [CODE_W-1:0] CODE_RESET = 3'd2;

  function automatic logic [HALF_W-1:0] half_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    half_of = 6'd21;
      3'd1:    half_of = 6'd31;
      3'd2:    half_of = 6'd8;
      3'd3:    half_of = 6'd13;
      default: half_of = 6'd51;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
#(
  parameter int CNT_W = HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == half_i - CNT_W'(1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 rd_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 oe_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o
);
  logic                 active_q;
  logic                 rd_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [DATA_W-1:0]    cap_q;
  logic                 last_bit;
  logic                 in_data;

  assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign in_data  = (idx_q >= IDX_W'(FRAME_LEN - DATA_W));
  assign done_o   = active_q && fall_i && last_bit;
  assign oe_o     = active_q && !(rd_q && (idx_q >= IDX_W'(TA_POS)));
  assign mdio_o   = oe_o & sh_q[FRAME_LEN-1];
  assign rdata_o  = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      cap_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_q     <= rd_i;
      idx_q    <= '0;
      sh_q     <= frame_i;
    end else if (active_q) begin
      if (rise_i && in_data) cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) active_q <= 1'b0;
        else begin
          idx_q <= idx_q + IDX_W'(1);
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              data_we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic [DATA_W-1:0] data_rdata_o,
  output logic              mdc_o,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic              busy_q;
  logic              wr_q;
  logic [CODE_W-1:0] code_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic [DATA_W-1:0] data_q;

  logic                 accept;
  logic                 start;
  logic                 wr_new;
  logic [FRAME_LEN-1:0] frame;
  logic                 rise, fall, done;
  logic [DATA_W-1:0]    rdata;

  assign accept = ctrl_we_i && !busy_q;
  assign start  = accept && wdata_i[BUSY_BIT];
  assign wr_new = wdata_i[WR_BIT];

  assign frame = {{PREAMBLE_LEN{1'b1}}, 2'b01, (wr_new ? 2'b01 : 2'b10),
                  wdata_i[PHY_LSB +: ADDR_W], wdata_i[REG_LSB +: ADDR_W], 2'b10,
                  (wr_new ? data_q : DATA_W'(0))};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      code_q <= CODE_RESET;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
    end else begin
      if (accept) begin
        busy_q <= wdata_i[BUSY_BIT];
        wr_q   <= wr_new;
        code_q <= wdata_i[CODE_LSB +: CODE_W];
        phy_q  <= wdata_i[PHY_LSB +: ADDR_W];
        reg_q  <= wdata_i[REG_LSB +: ADDR_W];
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (done && !wr_q) data_q <= rdata;
      else if (data_we_i && !busy_q) data_q <= wdata_i[DATA_W-1:0];
    end
  end

  mdio_clk_div #(.CNT_W(HALF_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .half_i (half_of(code_q)),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .rd_i    (!wr_new),
    .frame_i (frame),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done),
    .rdata_o (rdata)
  );

  assign ctrl_rdata_o = {phy_q, reg_q, 1'b0, code_q, wr_q, busy_q};
  assign data_rdata_o = data_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              data_we_i,
  input logic [CTRL_W-1:0] wdata_i,
  input logic [CTRL_W-1:0] ctrl_rdata_o,
  input logic [DATA_W-1:0] data_rdata_o,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o
);
  logic              busy;
  logic [HALF_W-1:0] hi_cnt;

  assign busy = ctrl_rdata_o[BUSY_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else if (mdc_o) hi_cnt <= hi_cnt + HALF_W'(1);
    else hi_cnt <= '0;
  end

  p_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(ctrl_we_i && wdata_i[BUSY_BIT]));

  p_high_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> hi_cnt == half_of(ctrl_rdata_o[CODE_LSB +: CODE_W]));

  p_end_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> $fell(mdc_o));

  p_stable_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  p_ctrl_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(ctrl_rdata_o[CTRL_W-1:1]));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));

  p_data_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(data_rdata_o));
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic        data_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] ctrl_rd, data_rd;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mdio_master u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .data_we_i(data_we),
    .wdata_i(wdata), .ctrl_rdata_o(ctrl_rd), .data_rdata_o(data_rd),
    .mdc_o(mdc), .mdio_i(mdio_in), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected<195000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  // PHY model: records driven bits on MDC rise, answers reads after MDC fall
  logic [63:0] seen_bit, seen_oe;
  logic [15:0] resp_q = '0;
  int          nrise = 0;
  int          glitch = 0;
  logic        mdc_d = 1'b0, out_d = 1'b0, oe_d = 1'b0;

  always @(negedge clk) begin
    if (!ctrl_rd[0]) nrise = 0;
    if (mdc && mdc_d && (mdio_out !== out_d || mdio_oe !== oe_d)) glitch++;
    if (mdc && !mdc_d) begin
      if (nrise < 64) begin
        seen_bit[63-nrise] = mdio_out;
        seen_oe[63-nrise]  = mdio_oe;
      end
      nrise++;
    end
    if (!mdc && mdc_d) mdio_in = (nrise >= 48 && nrise < 64) ? resp_q[63-nrise] : 1'b1;
    mdc_d = mdc;
    out_d = mdio_out;
    oe_d  = mdio_oe;
  end

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'd0: return 42;
      3'd1: return 62;
      3'd2: return 16;
      3'd3: return 26;
      default: return 102;
    endcase
  endfunction

  function automatic logic [63:0] exp_bits(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  function automatic logic [15:0] ctrl_word(input bit go, input bit wr, input logic [2:0] code,
                                            input logic [4:0] phy, input logic [4:0] rg);
    return {phy, rg, 1'b0, code, wr, go};
  endfunction

  task automatic write_ctrl(input logic [15:0] v);
    ctrl_we = 1'b1; wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic write_data(input logic [15:0] v);
    data_we = 1'b1; wdata = v;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [2:0] code, input logic [15:0] d, input logic [15:0] resp,
                         input bit poke);
    logic [15:0] w, pre;
    logic [63:0] eb, eo;
    int cyc, g0, mism;
    if (wr) write_data(d);
    pre = data_rd;
    resp_q = resp;
    g0 = glitch;
    w = ctrl_word(1'b1, wr, code, phy, rg);
    write_ctrl(w);
    cyc = 0;
    while (ctrl_rd[0] === 1'b1 && cyc < 20000) begin
      if (poke && cyc == 5) begin
        write_ctrl(~w | 16'h0001);
        cyc++;
        check(ctrl_rd[15:1] == w[15:1], "R8 ctrl write ignored while busy", ctrl_rd, w);
        write_data(16'h5AA5);
        cyc++;
        check(data_rd == pre, "R11 data write ignored while busy", data_rd, pre);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    check(cyc == 64 * ratio_of(code), "R3 busy duration", cyc, 64 * ratio_of(code));
    eb = exp_bits(wr, phy, rg, wr ? d : 16'h0);
    eo = wr ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      if (seen_oe[i] !== eo[i]) mism++;
      else if (eo[i] && seen_bit[i] !== eb[i]) mism++;
    end
    if (wr) check(mism == 0, "R4 write frame", {seen_oe[31:0], seen_bit[31:0]}, {eo[31:0], eb[31:0]});
    else    check(mism == 0, "R5 read frame", {seen_oe[31:0], seen_bit[31:0]}, {eo[31:0], eb[31:0]});
    check(glitch == g0, "R7 MDIO stable while MDC high", glitch - g0, 0);
    if (!wr) check(data_rd == resp, "R6 read data", data_rd, resp);
    else     check(data_rd == d, "R4 data register kept", data_rd, d);
    check(ctrl_rd == (w & 16'hFFFE), "R9 fields kept after completion", ctrl_rd, w & 16'hFFFE);
    check(!mdc && !mdio_oe, "R10 idle bus", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    check(ctrl_rd == 16'h0008, "R1 reset control word (code 2)", ctrl_rd, 16'h0008);
    check(!mdc && !mdio_oe && data_rd == 0, "R1 reset bus idle", {mdc, mdio_oe, data_rd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: fields without launch
    write_ctrl(ctrl_word(1'b0, 1'b1, 3'd3, 5'h15, 5'h0A));
    repeat (40) @(negedge clk);
    check(ctrl_rd == ctrl_word(1'b0, 1'b1, 3'd3, 5'h15, 5'h0A), "R2 fields without launch",
          ctrl_rd, ctrl_word(1'b0, 1'b1, 3'd3, 5'h15, 5'h0A));
    check(!mdc && !mdio_oe, "R2 no frame started", {mdc, mdio_oe}, 0);

    // directed corners
    run_txn(1'b1, 5'h1F, 5'h1F, 3'd2, 16'hFFFF, 16'h0, 1'b0);
    run_txn(1'b0, 5'h00, 5'h00, 3'd2, 16'h0, 16'hFFFF, 1'b0);
    run_txn(1'b0, 5'h11, 5'h05, 3'd3, 16'h0, 16'h8001, 1'b1);
    run_txn(1'b1, 5'h02, 5'h1D, 3'd0, 16'h1234, 16'h0, 1'b1);
    run_txn(1'b0, 5'h0C, 5'h13, 3'd1, 16'h0, 16'hBEEF, 1'b0);
    run_txn(1'b1, 5'h07, 5'h01, 3'd4, 16'h0000, 16'h0, 1'b0);
    run_txn(1'b0, 5'h1A, 5'h09, 3'd7, 16'h0, 16'h6C3A, 1'b0);

    for (int k = 0; k < 16; k++) begin
      logic [2:0] c;
      c = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'(2 + $urandom % 2);
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), c, 16'($urandom), 16'($urandom),
              ($urandom % 3) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule